// File: doc/BRIEF.md
# Delayed Read and Read-Ahead Tracker

This block decides how a bridge slave answers host transactions aimed at a slow local side. When delayed reads are switched on, the first read that arrives while nothing is outstanding is captured (address, command, byte enables). The block asks for a local fetch at that address and tells the host to retry. Later attempts are also told to retry until the local side reports that the data is in the FIFO. The read that finally completes the request must match the captured attributes exactly. A read that does not match is told to retry and leaves the pending request alone.

Writes that arrive while a read is outstanding follow one of two policies chosen by a configuration input. Under the first, the write is refused with retry. Under the second, the write is accepted and the pending read, together with any data already prefetched, is discarded with a FIFO flush. With read-ahead switched on, a completed read leaves the prefetched stream in place. The next read is then served straight from the FIFO, but only if its address is the previous one plus four and word aligned. Any other read flushes the FIFO and starts a fresh delayed read. If the host never comes back for ready data, a programmable timeout discards it.

The decision for a request appears on the outputs one clock after the request cycle. Bus signalling and the FIFO itself are outside the block.

Top module: `drt_tracker`

## Requirements
- R1: During and right after reset, rsp_valid, rsp_retry, fifo_flush and fetch_start are all 0.
- R2: Each request produces rsp_valid exactly one cycle later. With cfg_delayed_en=1 and nothing outstanding, a read receives rsp_retry=1 and fetch_start=1 in that cycle, with fetch_addr equal to the read address.
- R3: While a read is outstanding, a read is retried and starts no fetch if the local data is not yet ready, or if its address, command or byte enables differ from the captured ones.
- R4: After loc_done, a read matching all captured attributes is accepted (rsp_retry=0). With cfg_read_ahead=0 it also pulses fifo_flush and clears the outstanding state, so the same read afterwards starts a new fetch.
- R5: With cfg_write_flush=0, a write while a read is outstanding is retried with no flush, and the outstanding read is kept.
- R6: With cfg_write_flush=1, a write while a read is outstanding is accepted with fifo_flush=1, and the outstanding read is dropped.
- R7: With cfg_read_ahead=1, after a delivered read a read at exactly the last served address plus 4 with address bits [1:0]=0 is accepted with no fetch and no flush. Successive sequential reads chain.
- R8: With cfg_read_ahead=1, a read after delivery at any other address, or at a misaligned one, is retried with fifo_flush=1, fetch_start=1 and fetch_addr equal to its address.
- R9: A write while read-ahead data is held is accepted and pulses fifo_flush.
- R10: Ready data that no matching read collects is discarded: the outputs show fifo_flush on the (cfg_discard+1)-th clock edge after the edge that saw loc_done, and never before.
- R11: With cfg_delayed_en=0, every request is accepted; reads pulse fetch_start with their address and writes do not.
- R12: With nothing outstanding and no read-ahead data held, a write is accepted with no flush and no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delayed_en | input | 1 | Enables delayed-read handling |
| cfg_write_flush | input | 1 | 1: a write during a pending read is accepted and flushes; 0: it is retried |
| cfg_read_ahead | input | 1 | Enables serving sequential reads from prefetched data |
| cfg_discard | input | TW | Cycles ready data waits for the host before it is discarded |
| req_valid | input | 1 | A host transaction attempt is presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte address of the attempt |
| req_cmd | input | CW | Bus command code of the attempt |
| req_be | input | BW | Byte enables of the attempt |
| loc_done | input | 1 | Local fetch for the pending read has filled the FIFO |
| rsp_valid | output | 1 | A decision is presented (one cycle after req_valid) |
| rsp_retry | output | 1 | 1: tell the host to retry; 0: accept |
| fifo_flush | output | 1 | One-cycle pulse: discard FIFO contents |
| fetch_start | output | 1 | One-cycle pulse: start a local read fetch |
| fetch_addr | output | AW | Address for the local fetch |

## Verification
A wrong state shows as a wrong decision on the very next request. A stale pending flag turns an accept into a retry, or a retry into an accept, one cycle after the host repeats the read. A lost capture shows as a second fetch_start for a read that should have matched. A wrong read-ahead address shows as a flush or fetch where a direct accept was due, or the other way round. A miscounting discard timer moves the fifo_flush pulse off its edge, so the bench checks each edge of the window separately.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_AHEAD = 2'd3
    } trk_state_e;

    typedef struct packed {
        logic valid;
        logic retry;
        logic flush;
        logic fetch;
    } decision_t;

    localparam int WORD_BYTES = 4;

    function automatic logic word_aligned(input logic [1:0] low_bits);
        return low_bits == 2'b00;
    endfunction

endpackage

// File: rtl/drt_match.sv
module drt_match #(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int BW = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_cmd,
    input  logic [BW-1:0] cur_be,
    input  logic [AW-1:0] held_addr,
    input  logic [CW-1:0] held_cmd,
    input  logic [BW-1:0] held_be,
    output logic          same_req,
    output logic          next_word
);
    import drt_pkg::*;

    logic [AW-1:0] succ_addr;

    assign succ_addr = held_addr + AW'(WORD_BYTES);
    assign same_req  = (cur_addr == held_addr) && (cur_cmd == held_cmd) && (cur_be == held_be);
    assign next_word = (cur_addr == succ_addr) && word_aligned(cur_addr[1:0]);

endmodule

// File: rtl/drt_discard_timer.sv
module drt_discard_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/drt_tracker.sv
module drt_tracker #(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int BW = 4,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_delayed_en,
    input  logic          cfg_write_flush,
    input  logic          cfg_read_ahead,
    input  logic [TW-1:0] cfg_discard,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_cmd,
    input  logic [BW-1:0] req_be,
    input  logic          loc_done,
    output logic          rsp_valid,
    output logic          rsp_retry,
    output logic          fifo_flush,
    output logic          fetch_start,
    output logic [AW-1:0] fetch_addr
);
    import drt_pkg::*;

    trk_state_e    state, nstate;
    decision_t     dec, dec_q;
    logic          capture, move_last;
    logic [AW-1:0] held_addr;
    logic [CW-1:0] held_cmd;
    logic [BW-1:0] held_be;
    logic          same_req, next_word, expired;
    logic          busy;

    assign busy = (state == ST_WAIT) || (state == ST_READY);

    drt_match #(.AW(AW), .CW(CW), .BW(BW)) u_match (
        .cur_addr (req_addr),
        .cur_cmd  (req_cmd),
        .cur_be   (req_be),
        .held_addr(held_addr),
        .held_cmd (held_cmd),
        .held_be  (held_be),
        .same_req (same_req),
        .next_word(next_word)
    );

    drt_discard_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_READY),
        .limit  (cfg_discard),
        .expired(expired)
    );

    always_comb begin
        nstate    = state;
        dec       = '0;
        capture   = 1'b0;
        move_last = 1'b0;
        if (req_valid) begin
            dec.valid = 1'b1;
            if (!cfg_delayed_en) begin
                dec.fetch = !req_write;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (!req_write) begin
                            capture   = 1'b1;
                            dec.retry = 1'b1;
                            dec.fetch = 1'b1;
                            nstate    = ST_WAIT;
                        end
                    end
                    ST_WAIT, ST_READY: begin
                        if (req_write) begin
                            if (cfg_write_flush) begin
                                dec.flush = 1'b1;
                                nstate    = ST_IDLE;
                            end else begin
                                dec.retry = 1'b1;
                            end
                        end else if (same_req && state == ST_READY) begin
                            if (cfg_read_ahead) begin
                                move_last = 1'b1;
                                nstate    = ST_AHEAD;
                            end else begin
                                dec.flush = 1'b1;
                                nstate    = ST_IDLE;
                            end
                        end else begin
                            dec.retry = 1'b1;
                        end
                    end
                    ST_AHEAD: begin
                        if (req_write) begin
                            dec.flush = 1'b1;
                            nstate    = ST_IDLE;
                        end else if (next_word) begin
                            move_last = 1'b1;
                        end else begin
                            capture   = 1'b1;
                            dec.retry = 1'b1;
                            dec.flush = 1'b1;
                            dec.fetch = 1'b1;
                            nstate    = ST_WAIT;
                        end
                    end
                    default: nstate = ST_IDLE;
                endcase
            end
        end
        if (cfg_delayed_en && nstate == state) begin
            if (state == ST_WAIT && loc_done) begin
                nstate = ST_READY;
            end else if (state == ST_READY && expired) begin
                dec.flush = 1'b1;
                nstate    = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            dec_q      <= '0;
            held_addr  <= '0;
            held_cmd   <= '0;
            held_be    <= '0;
            fetch_addr <= '0;
        end else begin
            state <= nstate;
            dec_q <= dec;
            if (capture) begin
                held_addr <= req_addr;
                held_cmd  <= req_cmd;
                held_be   <= req_be;
            end else if (move_last) begin
                held_addr <= req_addr;
            end
            if (dec.fetch) begin
                fetch_addr <= req_addr;
            end
        end
    end

    assign rsp_valid   = dec_q.valid;
    assign rsp_retry   = dec_q.retry;
    assign fifo_flush  = dec_q.flush;
    assign fetch_start = dec_q.fetch;

endmodule

// File: rtl/drt_tracker_chk.sv
module drt_tracker_chk (
    input logic clk,
    input logic rst,
    input logic cfg_delayed_en,
    input logic cfg_write_flush,
    input logic req_valid,
    input logic req_write,
    input logic busy,
    input logic rsp_valid,
    input logic rsp_retry,
    input logic fifo_flush,
    input logic fetch_start
);

    p_rsp_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    p_fetch_from_read_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> $past(req_valid && !req_write));

    p_fetch_means_retry_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && $past(cfg_delayed_en)) |-> rsp_retry);

    p_write_refused_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cfg_delayed_en && !cfg_write_flush && busy) |=> (rsp_retry && !fifo_flush));

    p_write_flushes_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cfg_delayed_en && cfg_write_flush && busy) |=> (!rsp_retry && fifo_flush));

    p_no_retry_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_delayed_en) |=> (rsp_valid && !rsp_retry));

    p_idle_write_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cfg_delayed_en && !busy) |=> (!rsp_retry && !fetch_start));

endmodule

bind drt_tracker drt_tracker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_delayed_en (cfg_delayed_en),
    .cfg_write_flush(cfg_write_flush),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .busy           (busy),
    .rsp_valid      (rsp_valid),
    .rsp_retry      (rsp_retry),
    .fifo_flush     (fifo_flush),
    .fetch_start    (fetch_start)
);

// File: tb/sim_drt_tracker.sv
`timescale 1ns/1ps
module sim_drt_tracker;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam int BW = 4;
    localparam int TW = 8;
    localparam int DISCARD = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_delayed_en = 1'b1;
    logic          cfg_write_flush = 1'b0;
    logic          cfg_read_ahead = 1'b0;
    logic [TW-1:0] cfg_discard = TW'(DISCARD);
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_cmd = '0;
    logic [BW-1:0] req_be = '0;
    logic          loc_done = 1'b0;
    logic          rsp_valid, rsp_retry, fifo_flush, fetch_start;
    logic [AW-1:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    drt_tracker #(.AW(AW), .CW(CW), .BW(BW), .TW(TW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_delayed_en(cfg_delayed_en), .cfg_write_flush(cfg_write_flush),
        .cfg_read_ahead(cfg_read_ahead), .cfg_discard(cfg_discard),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_be(req_be), .loc_done(loc_done),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .fifo_flush(fifo_flush),
        .fetch_start(fetch_start), .fetch_addr(fetch_addr)
    );

    task automatic check_bits(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {valid,retry,flush,fetch} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_addr(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s fetch_addr actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle; on return the decision is on the outputs.
    task automatic send(input logic wr, input logic [AW-1:0] a, input logic [CW-1:0] c, input logic [BW-1:0] b);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_cmd   = c;
        req_be    = b;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic r, input logic f, input logic fe);
        check_bits(tag, {rsp_valid, rsp_retry, fifo_flush, fetch_start}, {1'b1, r, f, fe});
    endtask

    task automatic local_done();
        loc_done = 1'b1;
        @(negedge clk);
        loc_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [AW-1:0] ADDR_A = 32'h0000_0100;
    localparam logic [AW-1:0] ADDR_B = 32'h0000_0340;
    localparam logic [CW-1:0] CMD_RD = 4'h6;
    localparam logic [BW-1:0] BE_ALL = 4'hF;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check_bits("R1 reset", {rsp_valid, rsp_retry, fifo_flush, fetch_start}, 4'b0000);

        // R12: write with nothing outstanding
        send(1'b1, 32'h40, 4'h7, BE_ALL);
        expect_rsp("R12 idle write", 1'b0, 1'b0, 1'b0);

        // R2: new read is captured, retried and fetched
        send(1'b0, ADDR_A, CMD_RD, BE_ALL);
        expect_rsp("R2 first read", 1'b1, 1'b0, 1'b1);
        check_addr("R2 fetch address", fetch_addr, ADDR_A);

        // R3: repeat before data ready, and mismatches
        send(1'b0, ADDR_A, CMD_RD, BE_ALL);
        expect_rsp("R3 repeat not ready", 1'b1, 1'b0, 1'b0);
        for (int m = 0; m < 3; m++) begin
            send(1'b0, ADDR_A + ((m == 0) ? 32'd4 : 32'd0),
                 CMD_RD ^ ((m == 1) ? 4'h1 : 4'h0),
                 BE_ALL ^ ((m == 2) ? 4'h1 : 4'h0));
            expect_rsp("R3 mismatch while waiting", 1'b1, 1'b0, 1'b0);
        end

        // R5: write refused, pending kept
        send(1'b1, 32'h80, 4'h7, BE_ALL);
        expect_rsp("R5 write refused", 1'b1, 1'b0, 1'b0);

        local_done();
        for (int m = 0; m < 3; m++) begin
            send(1'b0, ADDR_A + ((m == 0) ? 32'd8 : 32'd0),
                 CMD_RD ^ ((m == 1) ? 4'h2 : 4'h0),
                 BE_ALL ^ ((m == 2) ? 4'h8 : 4'h0));
            expect_rsp("R3 mismatch when ready", 1'b1, 1'b0, 1'b0);
        end

        // R4: matching read delivered, then cleared (R5 showed the pending read was kept)
        send(1'b0, ADDR_A, CMD_RD, BE_ALL);
        expect_rsp("R4 matching read accepted", 1'b0, 1'b1, 1'b0);
        send(1'b0, ADDR_A, CMD_RD, BE_ALL);
        expect_rsp("R4 state cleared, new fetch", 1'b1, 1'b0, 1'b1);

        // R6: write-and-flush policy, both while waiting and while ready
        cfg_write_flush = 1'b1;
        send(1'b1, 32'h80, 4'h7, BE_ALL);
        expect_rsp("R6 write flushes waiting read", 1'b0, 1'b1, 1'b0);
        send(1'b0, ADDR_A, CMD_RD, BE_ALL);
        expect_rsp("R6 read dropped, new fetch", 1'b1, 1'b0, 1'b1);
        local_done();
        send(1'b1, 32'h84, 4'h7, BE_ALL);
        expect_rsp("R6 write flushes ready read", 1'b0, 1'b1, 1'b0);

        // R10: discard timeout, checked edge by edge
        send(1'b0, ADDR_B, CMD_RD, BE_ALL);
        expect_rsp("R10 setup read", 1'b1, 1'b0, 1'b1);
        local_done();
        for (int k = 1; k <= DISCARD + 1; k++) begin
            @(negedge clk);
            check_bits("R10 discard edge", {1'b0, fifo_flush}, {1'b0, (k == DISCARD + 1)});
        end
        send(1'b0, ADDR_B, CMD_RD, BE_ALL);
        expect_rsp("R10 discarded, new fetch", 1'b1, 1'b0, 1'b1);
        send(1'b1, 32'h0, 4'h7, BE_ALL);
        expect_rsp("R6 clear before read-ahead", 1'b0, 1'b1, 1'b0);

        // R7/R8/R9: sweep of follow-up offsets over aligned and misaligned bases
        cfg_read_ahead = 1'b1;
        for (int bi = 0; bi < 2; bi++) begin
            for (int oi = 0; oi < 9; oi++) begin
                automatic logic [AW-1:0] base = (bi == 0) ? 32'h200 : 32'h202;
                automatic int off = (oi == 8) ? -4 : (oi * 1);
                automatic logic [AW-1:0] nxt = base + AW'(off);
                automatic logic hit = (off == 4) && (nxt[1:0] == 2'b00);
                send(1'b0, base, CMD_RD, BE_ALL);
                expect_rsp("R2 read-ahead setup", 1'b1, 1'b0, 1'b1);
                local_done();
                send(1'b0, base, CMD_RD, BE_ALL);
                expect_rsp("R7 delivery keeps data", 1'b0, 1'b0, 1'b0);
                send(1'b0, nxt, CMD_RD, BE_ALL);
                if (hit) begin
                    expect_rsp("R7 sequential hit", 1'b0, 1'b0, 1'b0);
                    send(1'b0, nxt + 32'd4, CMD_RD, BE_ALL);
                    expect_rsp("R7 chained hit", 1'b0, 1'b0, 1'b0);
                    send(1'b1, 32'h10, 4'h7, BE_ALL);
                    expect_rsp("R9 write drops read-ahead", 1'b0, 1'b1, 1'b0);
                end else begin
                    expect_rsp("R8 read-ahead miss", 1'b1, 1'b1, 1'b1);
                    check_addr("R8 miss fetch address", fetch_addr, nxt);
                    send(1'b1, 32'h10, 4'h7, BE_ALL);
                    expect_rsp("R6 write clears miss fetch", 1'b0, 1'b1, 1'b0);
                end
            end
        end

        // R11: delayed reads disabled
        cfg_delayed_en = 1'b0;
        send(1'b0, 32'h500, CMD_RD, BE_ALL);
        expect_rsp("R11 read accepted directly", 1'b0, 1'b0, 1'b1);
        check_addr("R11 fetch address", fetch_addr, 32'h500);
        send(1'b0, 32'h500, CMD_RD, BE_ALL);
        expect_rsp("R11 repeat accepted directly", 1'b0, 1'b0, 1'b1);
        send(1'b1, 32'h504, 4'h7, BE_ALL);
        expect_rsp("R11 write accepted", 1'b0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule